// File: doc/BRIEF.md
# Three-Wire Serial Control Receiver

This block takes 16-bit control words from a write-only three-wire serial port and hands each one to a register bank as a single write. The three pins are a serial clock, a serial data line and a latch strobe. All three are sampled by a faster system clock. Each pin goes through a two-flop synchronizer, and rising edges are detected in the system clock domain. The system clock must run at least four times faster than the serial clock.

On every rising serial clock edge, one data bit enters a 16-bit shift register from the low end. A rising edge of the latch strobe captures whatever the shift register holds at that moment as the control word. How many bits came before does not matter: the strobe alone marks the end of a word. The upper seven bits of the word select a register and the lower nine bits are its new contents. The block presents both fields with a one-cycle write pulse.

A saturating counter records how many bits arrived since the last capture. If fewer than sixteen arrived, a flag reports that the captured word still holds stale bits from earlier traffic.

Top module: `serial_ctl_rx`

## Requirements
- R1: Each rising edge of `ser_clk`, as seen after synchronization, shifts the current `ser_dat` value into bit 0 and moves every held bit one place up. Bits therefore arrive MSB first: the earliest of the last 16 bits ends in word bit 15.
- R2: Each rising edge of `ser_latch` produces exactly one `wr_en` pulse, one `clk` cycle wide. The pulse is high on the cycle that follows the third rising `clk` edge, counting the first edge that samples `ser_latch` high after it was low. No `wr_en` pulse occurs without a latch edge.
- R3: During the pulse, `reg_addr` equals word bits 15..9 and `reg_data` equals word bits 8..0.
- R4: When more than 16 bits arrive before a latch edge, only the final 16 form the word. The bit counter never exceeds 16.
- R5: `short_word` is 1 with a pulse whose word was preceded by fewer than 16 bits since the previous capture or reset, and 0 otherwise. The shift register is not cleared by a capture, so a short word carries its new bits at the low end and older bits above them. A latch edge with no new bits re-issues the held contents.
- R6: `reg_addr`, `reg_data` and `short_word` keep their values from one pulse until the next, whatever serial traffic arrives in between.
- R7: A synchronous active-high `rst` clears the shift register, the bit counter, `wr_en`, `reg_addr`, `reg_data` and `short_word` to zero. A latch after a reset that cut a frame short yields word 0 with `short_word` 1.
- R8: Falling edges of `ser_clk` and changes of `ser_dat` while `ser_clk` stays low leave the shift register and the bit count unchanged.
- R9: When `ser_clk` and `ser_latch` rise in the same system cycle, the word is captured without that bit. That bit is still shifted in and counts as the first bit of the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_latch | input | 1 | Word latch strobe; a rising edge ends a word |
| wr_en | output | 1 | One-cycle register write pulse |
| reg_addr | output | 7 | Register select field of the captured word |
| reg_data | output | 9 | Register value field of the captured word |
| short_word | output | 1 | Captured word was preceded by fewer than 16 bits |

## Verification
The bench sends frames longer than a word to check that only the final sixteen bits survive. A design that kept the first sixteen, or wrapped its counter, would return the leading junk bits. It also sends short frames and a latch with no bits at all. A receiver that cleared its shift register on capture, or set the short flag wrongly, would show zeros in the upper field instead of the stale bits.

It raises the serial clock and the latch in the same system cycle. A design that sampled the shift register after the shift would capture a word with the new bit, and one that reset the counter without counting that bit would mark the following full word as short. Data wiggles with the clock held low, falling clock edges, and a reset in the middle of a frame expose designs that shift on the wrong edge or keep state across reset.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  // Default field widths of the control word.
  localparam int unsigned SCTL_ADDR_W = 7;
  localparam int unsigned SCTL_DATA_W = 9;

  // Depth of each input synchronizer.
  localparam int unsigned SCTL_SYNC_N = 2;

  // Number of asynchronous serial pins and their positions in the pin vector.
  localparam int unsigned SCTL_PINS   = 3;
  localparam int unsigned PIN_CLK     = 0;
  localparam int unsigned PIN_DAT     = 1;
  localparam int unsigned PIN_LAT     = 2;

  // Width of a counter that must reach n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sctl_edge.sv
module sctl_edge (
  input  logic clk,
  input  logic lvl,
  output logic rise
);

  logic lvl_q;

  // The previous level tracks the input even during reset, so no false
  // edge appears when reset releases while a line idles high.
  always_ff @(posedge clk) begin
    lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/sctl_shifter.sv
module sctl_shifter #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              restart,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  count
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  // New bit enters at the low end; the oldest bit falls off the top.
  function automatic logic [WORD_W-1:0] push_bit(
    input logic [WORD_W-1:0] w,
    input logic              b
  );
    return {w[WORD_W-2:0], b};
  endfunction

  // A capture restarts the count; a bit in the same cycle counts toward
  // the next word. The count saturates at one full word.
  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] c,
    input logic             restart_i,
    input logic             shift_i
  );
    logic [CNT_W-1:0] base;
    base = restart_i ? '0 : c;
    if (shift_i && (base != FULL)) begin
      base = base + CNT_W'(1);
    end
    return base;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      word  <= '0;
      count <= '0;
    end else begin
      if (shift_en) begin
        word <= push_bit(word, bit_in);
      end
      count <= step_count(count, restart, shift_en);
    end
  end

endmodule

// File: rtl/sctl_capture.sv
module sctl_capture #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 9,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [ADDR_W+DATA_W-1:0] word,
  input  logic [CNT_W-1:0]  count,
  output logic              wr_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_data,
  output logic              short_word
);

  localparam int unsigned WORD_W = ADDR_W + DATA_W;

  function automatic logic [ADDR_W-1:0] addr_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: ADDR_W];
  endfunction

  function automatic logic [DATA_W-1:0] data_of(input logic [WORD_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  function automatic logic is_short(input logic [CNT_W-1:0] c);
    return c < CNT_W'(WORD_W);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en      <= 1'b0;
      reg_addr   <= '0;
      reg_data   <= '0;
      short_word <= 1'b0;
    end else begin
      wr_en <= cap_en;
      if (cap_en) begin
        reg_addr   <= addr_of(word);
        reg_data   <= data_of(word);
        short_word <= is_short(count);
      end
    end
  end

endmodule

// File: rtl/serial_ctl_rx.sv
module serial_ctl_rx #(
  parameter int unsigned ADDR_W = sctl_pkg::SCTL_ADDR_W,
  parameter int unsigned DATA_W = sctl_pkg::SCTL_DATA_W,
  parameter int unsigned SYNC_N = sctl_pkg::SCTL_SYNC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_latch,
  output logic              wr_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_data,
  output logic              short_word
);

  localparam int unsigned WORD_W = ADDR_W + DATA_W;
  localparam int unsigned CNT_W  = sctl_pkg::cnt_width(WORD_W);
  localparam int unsigned NPIN   = sctl_pkg::SCTL_PINS;

  // Named internal events, also observed by the bound checker.
  logic [NPIN-1:0]   pin_raw;
  logic [NPIN-1:0]   pin_sync;
  logic              sclk_s;
  logic              dat_s;
  logic              latch_s;
  logic              sclk_rise;
  logic              latch_rise;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  always_comb begin
    pin_raw = '0;
    pin_raw[sctl_pkg::PIN_CLK] = ser_clk;
    pin_raw[sctl_pkg::PIN_DAT] = ser_dat;
    pin_raw[sctl_pkg::PIN_LAT] = ser_latch;
  end

  generate
    for (genvar g = 0; g < NPIN; g++) begin : g_sync
      sctl_sync #(
        .STAGES(SYNC_N)
      ) u_sync (
        .clk(clk),
        .d  (pin_raw[g]),
        .q  (pin_sync[g])
      );
    end
  endgenerate

  assign sclk_s  = pin_sync[sctl_pkg::PIN_CLK];
  assign dat_s   = pin_sync[sctl_pkg::PIN_DAT];
  assign latch_s = pin_sync[sctl_pkg::PIN_LAT];

  sctl_edge u_sclk_edge (
    .clk (clk),
    .lvl (sclk_s),
    .rise(sclk_rise)
  );

  sctl_edge u_latch_edge (
    .clk (clk),
    .lvl (latch_s),
    .rise(latch_rise)
  );

  sctl_shifter #(
    .WORD_W(WORD_W),
    .CNT_W (CNT_W)
  ) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .shift_en(sclk_rise),
    .bit_in  (dat_s),
    .restart (latch_rise),
    .word    (shreg),
    .count   (bit_cnt)
  );

  sctl_capture #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_capture (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (latch_rise),
    .word      (shreg),
    .count     (bit_cnt),
    .wr_en     (wr_en),
    .reg_addr  (reg_addr),
    .reg_data  (reg_data),
    .short_word(short_word)
  );

endmodule

// File: rtl/serial_ctl_rx_chk.sv
module serial_ctl_rx_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 9,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk_rise,
  input logic              latch_rise,
  input logic              dat_s,
  input logic [WORD_W-1:0] shreg,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_data,
  input logic              short_word
);

  assert_shift_lsb_R1: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> shreg[0] == $past(dat_s));

  assert_shift_order_R1: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> shreg[WORD_W-1:1] == $past(shreg[WORD_W-2:0]));

  assert_one_cycle_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  assert_pulse_after_latch_R2: assert property (@(posedge clk) disable iff (rst)
    latch_rise |=> wr_en);

  assert_no_spurious_write_R2: assert property (@(posedge clk) disable iff (rst)
    !latch_rise |=> !wr_en);

  assert_fields_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> {reg_addr, reg_data} == $past(shreg));

  assert_count_cap_R4: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(WORD_W));

  assert_short_flag_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> short_word == ($past(bit_cnt) < CNT_W'(WORD_W)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !$past(rst)) |-> $stable({reg_addr, reg_data, short_word}));

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (shreg == '0 && bit_cnt == '0 && !wr_en));

  assert_idle_shift_R8: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(shreg));

endmodule

bind serial_ctl_rx serial_ctl_rx_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .WORD_W(WORD_W),
  .CNT_W (CNT_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .sclk_rise (sclk_rise),
  .latch_rise(latch_rise),
  .dat_s     (dat_s),
  .shreg     (shreg),
  .bit_cnt   (bit_cnt),
  .wr_en     (wr_en),
  .reg_addr  (reg_addr),
  .reg_data  (reg_data),
  .short_word(short_word)
);

// File: tb/serial_ctl_rx_tb_top.sv
module serial_ctl_rx_tb_top;

  localparam int H = 3;  // system cycles per serial half period

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst  = 1'b1;
  logic sclk = 1'b0;
  logic sdat = 1'b0;
  logic slat = 1'b1;

  logic       wr_en;
  logic [6:0] reg_addr;
  logic [8:0] reg_data;
  logic       short_word;

  serial_ctl_rx dut_i (
    .clk       (clk),
    .rst       (rst),
    .ser_clk   (sclk),
    .ser_dat   (sdat),
    .ser_latch (slat),
    .wr_en     (wr_en),
    .reg_addr  (reg_addr),
    .reg_data  (reg_data),
    .short_word(short_word)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {bit c; bit d; bit l;} pin_t;
  pin_t hist[$];          // hist[0] newest pin sample
  bit   mbits[$];         // last 16 bits, index 0 oldest
  int   mcnt = 0;
  bit   model_live = 1'b0;
  logic       e_wr = 1'b0;
  logic [6:0] e_addr = '0;
  logic [8:0] e_data = '0;
  logic       e_short = 1'b0;

  initial begin
    repeat (16) mbits.push_back(1'b0);
  end

  always @(posedge clk) begin
    pin_t now;
    bit lr;
    bit sr;
    logic [15:0] w;
    now.c = sclk; now.d = sdat; now.l = slat;
    lr = 1'b0; sr = 1'b0;
    if (hist.size() >= 3) begin
      lr = hist[1].l && !hist[2].l;
      sr = hist[1].c && !hist[2].c;
    end
    if (rst) begin
      mbits.delete();
      repeat (16) mbits.push_back(1'b0);
      mcnt = 0; e_wr = 1'b0; e_addr = '0; e_data = '0; e_short = 1'b0;
    end else begin
      e_wr = 1'b0;
      if (lr) begin
        for (int i = 0; i < 16; i++) w[15-i] = mbits[i];
        e_wr = 1'b1; e_addr = w[15:9]; e_data = w[8:0];
        e_short = (mcnt < 16); mcnt = 0;
      end
      if (sr) begin
        mbits.push_back(hist[1].d);
        void'(mbits.pop_front());
        if (mcnt < 16) mcnt++;
      end
    end
    hist.push_front(now);
    if (hist.size() > 3) void'(hist.pop_back());
    model_live = 1'b1;
  end

  always @(negedge clk) begin
    if (model_live && !done) begin
      chk(wr_en === e_wr, "R2 model wr_en", 32'(wr_en), 32'(e_wr));
      chk({reg_addr, reg_data, short_word} === {e_addr, e_data, e_short},
          "R3/R6 model fields", 32'({reg_addr, reg_data, short_word}),
          32'({e_addr, e_data, e_short}));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdat = b; sclk = 1'b0; cyc(H);
    sclk = 1'b1; cyc(H);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic frame_start();
    slat = 1'b0; sclk = 1'b0; cyc(H);
  endtask

  // Raises the latch (and optionally the serial clock in the same cycle)
  // and checks the write pulse position and width.
  task automatic latch_word(input bit with_clk);
    slat = 1'b1;
    if (with_clk) sclk = 1'b1;
    cyc(2);
    chk(wr_en == 1'b0, "R2 no pulse before third edge", 32'(wr_en), 32'd0);
    cyc(1);
    chk(wr_en == 1'b1, "R2 pulse after third edge", 32'(wr_en), 32'd1);
    cyc(1);
    chk(wr_en == 1'b0, "R2 pulse one cycle wide", 32'(wr_en), 32'd0);
    cyc(2);
  endtask

  task automatic check_word(input logic [15:0] w, input logic sh, input string tag);
    chk(reg_addr == w[15:9], {tag, " addr"}, 32'(reg_addr), 32'(w[15:9]));
    chk(reg_data == w[8:0],  {tag, " data"}, 32'(reg_data), 32'(w[8:0]));
    chk(short_word == sh,    {tag, " short flag"}, 32'(short_word), 32'(sh));
  endtask

  logic [15:0] w1, w2, x3, x6, x7, w9;

  initial begin
    w1 = {7'h2B, 9'h1C3};
    w2 = {7'h05, 9'h0AA};
    w9 = {7'h7F, 9'h001};
    cyc(6);
    // R7: reset state
    check_word(16'h0000, 1'b0, "R7 reset");
    chk(wr_en == 1'b0, "R7 reset wr_en", 32'(wr_en), 32'd0);
    rst = 1'b0;
    cyc(4);

    // R1, R3: full word, MSB first
    frame_start();
    send_bits(32'(w1), 16);
    latch_word(1'b0);
    check_word(w1, 1'b0, "R1 R3 full word");

    // R4: four extra leading bits are dropped
    frame_start();
    send_bits(32'hF, 4);
    send_bits(32'(w2), 16);
    latch_word(1'b0);
    check_word(w2, 1'b0, "R4 overlong frame");

    // R5: five bits only, stale bits above
    x3 = {w2[10:0], 5'b10110};
    frame_start();
    send_bits(32'b10110, 5);
    latch_word(1'b0);
    check_word(x3, 1'b1, "R5 short frame");

    // R5: latch with no bits re-issues held contents
    frame_start();
    latch_word(1'b0);
    check_word(x3, 1'b1, "R5 empty frame");

    // R8: data toggles with clock low, no effect
    frame_start();
    for (int i = 0; i < 6; i++) begin
      sdat = ~sdat; cyc(2);
    end
    latch_word(1'b0);
    check_word(x3, 1'b1, "R8 data without clock");

    // R6: outputs held while a new frame shifts in
    x6 = {x3[5:0], 10'h2D3};
    frame_start();
    send_bits(32'h2D3, 10);
    check_word(x3, 1'b1, "R6 hold between pulses");
    latch_word(1'b0);
    check_word(x6, 1'b1, "R5 ten bit frame");

    // R9: clock and latch rise together
    x7 = {x6[0], 15'h6A5C};
    frame_start();
    send_bits(32'h6A5C, 15);
    sclk = 1'b0; sdat = 1'b1; cyc(H);
    latch_word(1'b1);
    check_word(x7, 1'b1, "R9 coincident capture");
    frame_start();
    send_bits(32'h1234, 15);
    latch_word(1'b0);
    check_word({1'b1, 15'h1234}, 1'b0, "R9 coincident bit counted");

    // R7: reset in the middle of a frame
    frame_start();
    send_bits(32'hFF, 8);
    rst = 1'b1; cyc(2);
    rst = 1'b0;
    check_word(16'h0000, 1'b0, "R7 mid-frame reset");
    cyc(3);
    latch_word(1'b0);
    check_word(16'h0000, 1'b1, "R7 latch after reset");

    // R4: long frame of 56 bits
    frame_start();
    send_bits(32'hDEADBEEF, 32);
    send_bits(32'h3C, 8);
    send_bits(32'(w9), 16);
    latch_word(1'b0);
    check_word(w9, 1'b0, "R4 long frame");

    cyc(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule